// File: doc/BRIEF.md
# Hinted Branch Target Buffer

This block sits beside the instruction fetch unit and remembers where predicted-taken branches live. Every fetch address is looked up in the same cycle it is presented. On a hit the block raises a taken prediction and supplies the stored destination, so fetch can steer to the new line with no bubble. Loop-closing branches that stay in the buffer therefore cost nothing per iteration.

The direction of every branch is fixed by a static hint bit that the compiler places in the instruction. No counters learn at run time. When the execute stage resolves a branch, it reports the branch address, its hint, its real outcome and what fetch had predicted. The buffer adds or refreshes an entry for a hinted-taken branch. It drops the entry for a branch whose hint is clear or that software has withdrawn. When the real outcome differs from the prediction, it asks fetch to flush and restart at the corrected address.

Storage is set associative. The set is chosen by fetch-address bits just above the instruction byte offset, and the rest of the upper bits form the tag. Within a set, ways are reused in rotating order.

Top module: `hinted_btb`

## Requirements
- R1: After reset no entry is valid, `predict_taken` and `mispredict` are 0 and `redirect_pc` is 0.
- R2: The lookup is combinational. When `fetch_pc` matches a valid entry, `predict_taken` is 1 and `predict_target` carries that entry's destination in the same cycle. On a miss both outputs are 0.
- R3: A resolution with `resolve_hint`=1 and `resolve_remove`=0 that misses the buffer allocates an entry, whatever the real outcome was. A lookup of that address hits from the next cycle on. No address ever hits in more than one way.
- R4: The same kind of resolution that hits an existing entry overwrites only that entry's destination. No second copy is made and no other entry is disturbed.
- R5: A resolution with `resolve_hint`=0, or with `resolve_remove`=1, clears the matching entry. The entry misses from the next cycle on, and other entries are kept.
- R6: Each set keeps a rotating victim pointer that starts at way 0 after reset and advances only on an allocation. With the default 4 ways, the fifth allocation into one set evicts the first entry allocated there.
- R7: The set index is `pc[OFF+IW-1:OFF]` and the tag is the remaining upper bits, where OFF = log2(INSTR_BYTES) and IW = log2(SETS). The low OFF bits are ignored. Addresses in different sets never interfere.
- R8: `mispredict` is registered and is 1 in the cycle after a resolution in which the real direction differs from the predicted one, or in which both are taken but the targets differ. Otherwise it is 0, so each bad resolution gives a one-cycle pulse.
- R9: Along with `mispredict`, `redirect_pc` holds `resolve_target` when the branch was taken, and `resolve_pc + INSTR_BYTES` when it was not.
- R10: `flush_all` clears every valid bit in one cycle and wins over an update from a resolution in the same cycle. Mispredict reporting for that resolution is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate every entry |
| fetch_pc | input | AW | Address being fetched |
| predict_taken | output | 1 | Lookup hit, redirect fetch |
| predict_target | output | AW | Destination of the hit entry |
| resolve_valid | input | 1 | A branch resolution is presented |
| resolve_pc | input | AW | Address of the resolved branch |
| resolve_hint | input | 1 | Static taken hint from the instruction |
| resolve_remove | input | 1 | Software withdraws this branch |
| resolve_taken | input | 1 | Real direction of the branch |
| resolve_target | input | AW | Real destination of the branch |
| resolve_pred_taken | input | 1 | Direction fetch predicted |
| resolve_pred_target | input | AW | Destination fetch predicted |
| mispredict | output | 1 | One-cycle flush request to fetch |
| redirect_pc | output | AW | Corrected restart address |

## Verification
Two functions can fall in the same cycle: a global flush and a resolution that would allocate an entry and that also mispredicts. The bench raises `flush_all` while it presents a hinted-taken resolution whose real direction disagrees with the prediction. It then checks that the address still misses in the next cycle, and that `mispredict` and `redirect_pc` still report the corrected destination. In the same way, lookups and resolutions are presented together throughout. A lookup must show the table as it stood before that edge's update.

// File: rtl/hinted_btb.sv
module hinted_btb #(
  parameter int AW          = 32,
  parameter int SETS        = 32,
  parameter int WAYS        = 4,
  parameter int INSTR_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_all,
  input  logic [AW-1:0] fetch_pc,
  output logic          predict_taken,
  output logic [AW-1:0] predict_target,
  input  logic          resolve_valid,
  input  logic [AW-1:0] resolve_pc,
  input  logic          resolve_hint,
  input  logic          resolve_remove,
  input  logic          resolve_taken,
  input  logic [AW-1:0] resolve_target,
  input  logic          resolve_pred_taken,
  input  logic [AW-1:0] resolve_pred_target,
  output logic          mispredict,
  output logic [AW-1:0] redirect_pc
);
  localparam int OFF = $clog2(INSTR_BYTES);
  localparam int IW  = $clog2(SETS);
  localparam int WW  = $clog2(WAYS);
  localparam int TW  = AW - IW - OFF;

  logic [WAYS-1:0] valid_q [SETS];
  logic [WW-1:0]   rr_q    [SETS];
  logic [TW-1:0]   tag_q   [SETS][WAYS];
  logic [AW-1:0]   tgt_q   [SETS][WAYS];

  logic [IW-1:0]   f_idx, r_idx;
  logic [TW-1:0]   f_tag, r_tag;
  logic [WAYS-1:0] f_hit, r_hit;
  logic [WW-1:0]   r_way, wr_way;
  logic            r_hit_any, wr_en, drop_en, mp;

  assign f_idx = fetch_pc[OFF +: IW];
  assign f_tag = fetch_pc[AW-1 -: TW];
  assign r_idx = resolve_pc[OFF +: IW];
  assign r_tag = resolve_pc[AW-1 -: TW];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign f_hit[w] = valid_q[f_idx][w] && (tag_q[f_idx][w] == f_tag);
    assign r_hit[w] = valid_q[r_idx][w] && (tag_q[r_idx][w] == r_tag);
  end

  always_comb begin
    predict_target = '0;
    r_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (f_hit[w]) predict_target = predict_target | tgt_q[f_idx][w];
      if (r_hit[w]) r_way = WW'(w);
    end
  end

  assign predict_taken = |f_hit;
  assign r_hit_any     = |r_hit;
  assign wr_en   = resolve_valid && !flush_all && resolve_hint && !resolve_remove;
  assign drop_en = resolve_valid && !flush_all && (!resolve_hint || resolve_remove);
  assign wr_way  = r_hit_any ? r_way : rr_q[r_idx];
  assign mp = resolve_valid && ((resolve_taken != resolve_pred_taken) ||
              (resolve_taken && (resolve_target != resolve_pred_target)));

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[r_idx][wr_way] <= r_tag;
      tgt_q[r_idx][wr_way] <= resolve_target;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
      mispredict  <= 1'b0;
      redirect_pc <= '0;
    end else begin
      if (flush_all) begin
        for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else if (wr_en) begin
        valid_q[r_idx][wr_way] <= 1'b1;
        if (!r_hit_any) rr_q[r_idx] <= rr_q[r_idx] + 1'b1;
      end else if (drop_en) begin
        valid_q[r_idx] <= valid_q[r_idx] & ~r_hit;
      end
      mispredict <= mp;
      if (mp) redirect_pc <= resolve_taken ? resolve_target : resolve_pc + AW'(INSTR_BYTES);
    end
  end

  p_single_way_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(f_hit));
  p_alloc_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && fetch_pc == $past(resolve_pc)) |->
      (predict_taken && predict_target == $past(resolve_target)));
  p_drop_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drop_en) && fetch_pc == $past(resolve_pc)) |-> !predict_taken);
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !predict_taken);
  p_mispredict_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> $past(resolve_valid));
  p_fallthru_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mispredict && !$past(resolve_taken)) |->
      redirect_pc == $past(resolve_pc) + AW'(INSTR_BYTES));
endmodule

// File: tb/hinted_btb_tb.sv
`timescale 1ns/1ps
module hinted_btb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_all = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        predict_taken;
  logic [31:0] predict_target;
  logic        resolve_valid = 1'b0;
  logic [31:0] resolve_pc = '0;
  logic        resolve_hint = 1'b0;
  logic        resolve_remove = 1'b0;
  logic        resolve_taken = 1'b0;
  logic [31:0] resolve_target = '0;
  logic        resolve_pred_taken = 1'b0;
  logic [31:0] resolve_pred_target = '0;
  logic        mispredict;
  logic [31:0] redirect_pc;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hinted_btb u_dut (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all), .fetch_pc(fetch_pc),
    .predict_taken(predict_taken), .predict_target(predict_target),
    .resolve_valid(resolve_valid), .resolve_pc(resolve_pc),
    .resolve_hint(resolve_hint), .resolve_remove(resolve_remove),
    .resolve_taken(resolve_taken), .resolve_target(resolve_target),
    .resolve_pred_taken(resolve_pred_taken), .resolve_pred_target(resolve_pred_target),
    .mispredict(mispredict), .redirect_pc(redirect_pc)
  );

  // {req[3:0], rv, hint, remove, rpc, rtgt, lookup_pc, exp_hit, exp_tgt}
  localparam int NV = 17;
  localparam logic [135:0] VEC [NV] = '{
    {4'd1, 3'b000, 32'h0,    32'h0,    32'h1000, 1'b0, 32'h0},    // R1 empty
    {4'd3, 3'b110, 32'h1000, 32'h2000, 32'h1000, 1'b1, 32'h2000}, // R3 allocate
    {4'd7, 3'b000, 32'h0,    32'h0,    32'h1002, 1'b1, 32'h2000}, // R7 offset ignored
    {4'd7, 3'b000, 32'h0,    32'h0,    32'h1004, 1'b0, 32'h0},    // R7 other set
    {4'd4, 3'b110, 32'h1000, 32'h3000, 32'h1000, 1'b1, 32'h3000}, // R4 retarget
    {4'd4, 3'b110, 32'h1080, 32'h4000, 32'h1000, 1'b1, 32'h3000}, // R4 neighbour kept
    {4'd2, 3'b000, 32'h0,    32'h0,    32'h1080, 1'b1, 32'h4000}, // R2 hit
    {4'd5, 3'b100, 32'h1000, 32'h0,    32'h1000, 1'b0, 32'h0},    // R5 hint cleared
    {4'd5, 3'b000, 32'h0,    32'h0,    32'h1080, 1'b1, 32'h4000}, // R5 other kept
    {4'd5, 3'b111, 32'h1080, 32'h4000, 32'h1080, 1'b0, 32'h0},    // R5 removed
    {4'd6, 3'b110, 32'h1004, 32'hA004, 32'h1004, 1'b1, 32'hA004}, // R6 way0
    {4'd6, 3'b110, 32'h1084, 32'hA084, 32'h1004, 1'b1, 32'hA004}, // R6 way1
    {4'd6, 3'b110, 32'h1104, 32'hA104, 32'h1104, 1'b1, 32'hA104}, // R6 way2
    {4'd6, 3'b110, 32'h1184, 32'hA184, 32'h1184, 1'b1, 32'hA184}, // R6 way3
    {4'd6, 3'b110, 32'h1204, 32'hA204, 32'h1004, 1'b0, 32'h0},    // R6 oldest evicted
    {4'd6, 3'b000, 32'h0,    32'h0,    32'h1204, 1'b1, 32'hA204}, // R6 newcomer
    {4'd6, 3'b000, 32'h0,    32'h0,    32'h1084, 1'b1, 32'hA084}  // R6 survivor
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic resolve(logic [31:0] pc, logic hint, logic rem, logic tk,
                         logic [31:0] tgt, logic ptk, logic [31:0] ptgt, logic fl);
    @(negedge clk);
    resolve_valid = 1'b1; resolve_pc = pc; resolve_hint = hint;
    resolve_remove = rem; resolve_taken = tk; resolve_target = tgt;
    resolve_pred_taken = ptk; resolve_pred_target = ptgt; flush_all = fl;
    @(posedge clk);
    @(negedge clk);
    resolve_valid = 1'b0; flush_all = 1'b0;
  endtask

  task automatic lookup(logic [31:0] pc, string req, logic eh, logic [31:0] et);
    fetch_pc = pc;
    #1;
    chk(req, {31'b0, predict_taken}, {31'b0, eh});
    chk(req, predict_target, et);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 predict", {31'b0, predict_taken}, 32'd0);
    chk("R1 mispredict", {31'b0, mispredict}, 32'd0);
    chk("R1 redirect", redirect_pc, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [135:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d vec%0d", v[135:132], i);
      @(negedge clk);
      resolve_valid = v[131]; resolve_hint = v[130]; resolve_remove = v[129];
      resolve_pc = v[128:97]; resolve_target = v[96:65];
      resolve_taken = v[130]; resolve_pred_taken = v[130];
      resolve_pred_target = v[96:65];
      @(posedge clk);
      @(negedge clk);
      resolve_valid = 1'b0;
      lookup(v[64:33], rq, v[32], v[31:0]);
      chk("R8 no mispredict", {31'b0, mispredict}, 32'd0);
    end

    // R8 R9 predicted taken, fell through
    resolve(32'h2000, 1'b1, 1'b0, 1'b0, 32'h2400, 1'b1, 32'h2400, 1'b0);
    #1;
    chk("R8 dir mismatch", {31'b0, mispredict}, 32'd1);
    chk("R9 fallthrough", redirect_pc, 32'h2004);
    @(negedge clk); #1;
    chk("R8 pulse ends", {31'b0, mispredict}, 32'd0);

    // R9 predicted not taken, went taken
    resolve(32'h2100, 1'b0, 1'b0, 1'b1, 32'h5000, 1'b0, 32'h0, 1'b0);
    #1;
    chk("R8 late taken", {31'b0, mispredict}, 32'd1);
    chk("R9 taken target", redirect_pc, 32'h5000);

    // R8 wrong target
    resolve(32'h2200, 1'b1, 1'b0, 1'b1, 32'h6000, 1'b1, 32'h5000, 1'b0);
    #1;
    chk("R8 target mismatch", {31'b0, mispredict}, 32'd1);
    chk("R9 target fix", redirect_pc, 32'h6000);

    // R8 correct prediction
    resolve(32'h2300, 1'b1, 1'b0, 1'b1, 32'h6100, 1'b1, 32'h6100, 1'b0);
    #1;
    chk("R8 correct", {31'b0, mispredict}, 32'd0);
    lookup(32'h2200, "R3 alloc on mispredict", 1'b1, 32'h6000);

    // R10 flush alone
    resolve(32'h3000, 1'b1, 1'b0, 1'b1, 32'h7000, 1'b1, 32'h7000, 1'b0);
    lookup(32'h3000, "R3 pre-flush", 1'b1, 32'h7000);
    @(negedge clk); flush_all = 1'b1;
    @(posedge clk);
    @(negedge clk); flush_all = 1'b0;
    lookup(32'h3000, "R10 flushed", 1'b0, 32'h0);
    lookup(32'h1084, "R10 flushed other", 1'b0, 32'h0);

    // R10 flush together with an allocating, mispredicting resolution
    resolve(32'h3100, 1'b1, 1'b0, 1'b1, 32'h8000, 1'b0, 32'h0, 1'b1);
    #1;
    chk("R10 mispredict kept", {31'b0, mispredict}, 32'd1);
    chk("R10 redirect kept", redirect_pc, 32'h8000);
    lookup(32'h3100, "R10 flush wins", 1'b0, 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule